// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block wraps a small combinational logic cloud in a chain of mux-D scan flops. It adds a sequencer that runs a complete structural test on its own. A start pulse launches a serial load of a test vector, then one capture cycle in which every flop samples the cloud's response. The response is shifted out while the next vector is shifted in. The response bits are compared on chip against an expected serial stream. After the final pattern the block raises a one-cycle done pulse, a sticky fail flag and a count of mismatching bits.

When no test is running, the chain works as ordinary state. Each cycle it loads the cloud's output, and the flop contents are visible on the functional output bus. The tester supplies the serial vector bits and the serial expected bits at fixed cycles relative to start. These are plain per-cycle pins with no handshake: the sequencer never stalls, so the source must present the next bit in every shift cycle.

Top module: `scan_seq_top`

## Requirements
- R1: While scan_en is 1, each cycle moves every flop's content one place toward the last flop and loads scan_in into flop 0. While scan_en is 0, every flop loads its cloud output.
- R2: While idle, the chain loads the cloud every cycle, with next[i] = func_in[i] ^ q[(i+1)%N] ^ (q[i] & q[(i+N-1)%N]). func_out equals the chain contents q.
- R3: A start seen while idle begins a test. There are N load cycles with scan_en=1, then exactly one capture cycle with scan_en=0.
- R4: The first bit shifted in ends in the last flop (bit N-1), and scan_out always shows the last flop. After a load, func_out equals the loaded vector.
- R5: For num_pat patterns, each unload also shifts in the next vector over the same N cycles, followed by the next capture. A run takes N + num_pat*(N+1) cycles from start to the done cycle.
- R6: In every unload cycle, scan_out is compared with expect_bit. Any mismatch sets fail on the next cycle, and fail stays set until the next accepted start.
- R7: miss_cnt counts mismatching bits and saturates at its maximum value. Both miss_cnt and fail clear when a start is accepted.
- R8: busy is 1 from the cycle after start through the done cycle. done is 1 for exactly one cycle, right after the last unload cycle, and busy is 0 in the cycle after that.
- R9: A start while busy is ignored, and the run timing is unchanged.
- R10: num_pat = 0 runs a single pattern.
- R11: During reset, the chain is cleared and busy, done, fail, scan_en and miss_cnt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Test launch pulse |
| num_pat | input | PAT_W | Number of patterns in a run, sampled at start |
| func_in | input | N | Functional data inputs to the cloud |
| func_out | output | N | Chain contents |
| scan_in | input | 1 | Serial vector bit |
| expect_bit | input | 1 | Serial expected response bit |
| scan_out | output | 1 | Last flop of the chain |
| scan_en | output | 1 | 1 = shift, 0 = functional or capture |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| miss_cnt | output | CNT_W | Count of mismatching bits |

## Verification
A wrong shift count or a lost capture cycle moves the done pulse away from cycle N + num_pat*(N+1). It also skews every scan_out bit during the unload that follows, so the error shows within one pattern. A broken chain link or a wrong shift direction shows up as a mismatch between func_out and the loaded vector at the capture cycle. A corrupted compare path shows up as fail or miss_cnt disagreeing with the model when done rises. A cloud stuck-at fault is modelled in the expected stream and must raise fail.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_CAPT,
    SQ_XCHG,
    SQ_DONE
  } sq_state_t;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic se,
  input  logic d,
  input  logic si,
  output logic q
);
  logic nxt;

  always_comb nxt = se ? si : d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         se,
  input  logic         si,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N:0] link;

  assign link[0] = si;

  for (genvar i = 0; i < N; i++) begin : g_cell
    scan_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .se   (se),
      .d    (d[i]),
      .si   (link[i]),
      .q    (q[i])
    );
    assign link[i+1] = q[i];
  end
endmodule

// File: rtl/logic_cloud.sv
module logic_cloud #(
  parameter int N = 8
) (
  input  logic [N-1:0] q,
  input  logic [N-1:0] fi,
  output logic [N-1:0] y
);
  for (genvar i = 0; i < N; i++) begin : g_node
    assign y[i] = fi[i] ^ q[(i+1)%N] ^ (q[i] & q[(i+N-1)%N]);
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_seq_pkg::*;
#(
  parameter int N     = 8,
  parameter int PAT_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAT_W-1:0] num_pat,
  input  logic             so_bit,
  input  logic             expect_bit,
  output logic             scan_en,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] miss_cnt
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  sq_state_t        state;
  logic [CW-1:0]    cnt;
  logic [PAT_W-1:0] pat_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      pat_left <= '0;
      fail     <= 1'b0;
      miss_cnt <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start) begin
            state    <= SQ_LOAD;
            cnt      <= '0;
            pat_left <= (num_pat == '0) ? PAT_W'(1) : num_pat;
            fail     <= 1'b0;
            miss_cnt <= '0;
          end
        end
        SQ_LOAD: begin
          if (cnt == LAST) begin
            state <= SQ_CAPT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_CAPT: state <= SQ_XCHG;
        SQ_XCHG: begin
          if (so_bit != expect_bit) begin
            fail <= 1'b1;
            if (miss_cnt != '1) miss_cnt <= miss_cnt + 1'b1;
          end
          if (cnt == LAST) begin
            cnt <= '0;
            if (pat_left == PAT_W'(1)) begin
              state <= SQ_DONE;
            end else begin
              pat_left <= pat_left - 1'b1;
              state    <= SQ_CAPT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    scan_en = (state == SQ_LOAD) || (state == SQ_XCHG);
    busy    = (state != SQ_IDLE);
    done    = (state == SQ_DONE);
  end

  // R3
  capture_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_en && !done) |=> scan_en);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> fail);

  // R7
  cnt_flag_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail == (miss_cnt != '0));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int N     = 8,
  parameter int PAT_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAT_W-1:0] num_pat,
  input  logic [N-1:0]     func_in,
  output logic [N-1:0]     func_out,
  input  logic             scan_in,
  input  logic             expect_bit,
  output logic             scan_out,
  output logic             scan_en,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] miss_cnt
);
  logic [N-1:0] q;
  logic [N-1:0] cloud_y;

  logic_cloud #(.N(N)) u_cloud (
    .q (q),
    .fi(func_in),
    .y (cloud_y)
  );

  scan_chain #(.N(N)) u_chain (
    .clk  (clk),
    .rst_n(rst_n),
    .se   (scan_en),
    .si   (scan_in),
    .d    (cloud_y),
    .q    (q)
  );

  scan_ctrl #(.N(N), .PAT_W(PAT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .num_pat   (num_pat),
    .so_bit    (q[N-1]),
    .expect_bit(expect_bit),
    .scan_en   (scan_en),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .miss_cnt  (miss_cnt)
  );

  assign func_out = q;
  assign scan_out = q[N-1];

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (func_out == {$past(func_out[N-2:0]), $past(scan_in)}));

  // R4
  scan_out_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_out == func_out[N-1]);
endmodule

// File: tb/sim_scan_seq_top.sv
module sim_scan_seq_top;
  localparam int N     = 8;
  localparam int PAT_W = 4;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [PAT_W-1:0] num_pat;
  logic [N-1:0]     func_in;
  logic [N-1:0]     func_out;
  logic             scan_in;
  logic             expect_bit;
  logic             scan_out;
  logic             scan_en;
  logic             busy;
  logic             done;
  logic             fail;
  logic [CNT_W-1:0] miss_cnt;

  int n_chk  = 0;
  int n_bad  = 0;
  int faults_seen = 0;
  bit finished = 1'b0;
  logic [N-1:0] vec [0:15];

  always #10 clk = ~clk;

  scan_seq_top #(.N(N), .PAT_W(PAT_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .num_pat(num_pat),
    .func_in(func_in), .func_out(func_out), .scan_in(scan_in),
    .expect_bit(expect_bit), .scan_out(scan_out), .scan_en(scan_en),
    .busy(busy), .done(done), .fail(fail), .miss_cnt(miss_cnt)
  );

  function automatic logic [N-1:0] cloud(input logic [N-1:0] q, input logic [N-1:0] fi,
                                         input bit flt, input int fidx, input bit fval);
    logic [N-1:0] y;
    for (int i = 0; i < N; i++)
      y[i] = fi[i] ^ q[(i+1)%N] ^ (q[i] & q[(i+N-1)%N]);
    if (flt) y[fidx] = fval;
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int req, input bit flt, input int fidx, input bit fval, input bit poke);
    int eff;
    int exp_miss;
    logic [N-1:0] model, resp, expr;
    eff = (req == 0) ? 1 : req;
    exp_miss = 0;
    for (int p = 0; p < eff; p++) vec[p] = N'($urandom);
    @(negedge clk);
    num_pat = PAT_W'(req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    chk(scan_en == 1'b1, "R3 load scan_en", scan_en, 1);
    chk(fail == 1'b0 && miss_cnt == '0, "R7 clear on start", miss_cnt, 0);
    for (int k = 0; k < N; k++) begin
      scan_in = vec[0][N-1-k];
      start = (poke && k == 2);
      @(negedge clk);
    end
    start = 1'b0;
    chk(scan_en == 1'b0 && busy, "R3 capture cycle", scan_en, 0);
    chk(func_out == vec[0], "R4 loaded vector", func_out, vec[0]);
    model = vec[0];
    for (int p = 0; p < eff; p++) begin
      resp = cloud(model, func_in, 1'b0, 0, 1'b0);
      expr = cloud(model, func_in, flt, fidx, fval);
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
        chk(scan_out == resp[N-1-k], "R4 unload bit", scan_out, resp[N-1-k]);
        expect_bit = expr[N-1-k];
        if (resp[N-1-k] != expr[N-1-k]) exp_miss++;
        scan_in = (p + 1 < eff) ? vec[p+1][N-1-k] : 1'($urandom);
        @(negedge clk);
      end
      if (p + 1 < eff) begin
        chk(scan_en == 1'b0 && !done, "R5 next capture", scan_en, 0);
        chk(func_out == vec[p+1], "R5 overlapped load", func_out, vec[p+1]);
        model = vec[p+1];
      end
    end
    chk(done == 1'b1, (req == 0) ? "R10 done single pattern" : "R8 done timing", done, 1);
    chk(fail == (exp_miss > 0), "R6 fail flag", fail, exp_miss > 0);
    chk(miss_cnt == CNT_W'(exp_miss), "R7 miss count", miss_cnt, exp_miss);
    if (flt && fail) faults_seen++;
    if (poke) chk(done == 1'b1, "R9 start while busy ignored", done, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 done pulse ends", {done, busy}, 0);
    chk(fail == (exp_miss > 0), "R6 fail sticky after run", fail, exp_miss > 0);
    model = func_out;
    @(negedge clk);
    chk(func_out == cloud(model, func_in, 1'b0, 0, 1'b0), "R2 idle functional",
        func_out, cloud(model, func_in, 1'b0, 0, 1'b0));
    chk(scan_en == 1'b0, "R1 idle scan_en low", scan_en, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5ca9_1e07));
    rst_n = 1'b0; start = 1'b0; num_pat = '0; func_in = '0;
    scan_in = 1'b0; expect_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !scan_en && miss_cnt == '0, "R11 reset outputs",
        {busy, done, fail, scan_en}, 0);
    chk(func_out == '0, "R11 chain cleared", func_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    func_in = 8'h00;
    run(1, 1'b0, 0, 1'b0, 1'b0);
    func_in = 8'hFF;
    run(0, 1'b0, 0, 1'b0, 1'b0);
    run(3, 1'b0, 0, 1'b0, 1'b1);
    run(4, 1'b1, 3, 1'b1, 1'b0);
    run(2, 1'b0, 0, 1'b0, 1'b0);
    // random mix
    for (int t = 0; t < 12; t++) begin
      func_in = N'($urandom);
      run(1 + int'($urandom % 5), t[0], int'($urandom % N), 1'($urandom), t % 3 == 0);
    end
    chk(faults_seen > 0, "R6 stuck-at fault detected", faults_seen, 1);
    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule